// File: doc/BRIEF.md
# Stack Frame Release Sequencer

This block carries out the one-byte "leave procedure frame" instruction of a CISC processor core. When the decoder hands it an instruction, it copies the frame-pointer register into the stack-pointer register, reads the saved caller frame pointer from memory at that address, and returns both updated pointers. The copy and the pop are sized independently. The copy width follows the stack-address size. The pop width follows the operand size.

Before any memory traffic or register change, the block checks the request against the current processor mode. It looks for a LOCK prefix, for an address that falls outside the 64 KiB window or the stack limit, for a non-canonical 64-bit address, and for a misaligned pop under alignment checking. A page fault returned by the memory read also becomes an exception. The instruction either completes in full or leaves both pointers as they were. The surrounding core then writes `sp_o` and `bp_o` back to its register file on `done_o`, or takes the exception in `exc_o`.

Top module: `frame_release_seq`

## Requirements
- R1: A `start_i` pulse while idle with `opcode_i` = 0xC9 begins a sequence. A pulse with any other opcode, or one that arrives while a sequence is running, is ignored: no memory request, no `done_o`, and `sp_o`/`bp_o` keep their values.
- R2: If `lock_i` is set, the result is exception code 1 (invalid opcode), in every mode, and no memory read is issued.
- R3: In mode 0 (real) or mode 1 (virtual-8086), a stack address above 0xFFFF gives exception code 2 (general protection, error code 0).
- R4: In mode 2 (protected) or mode 3 (compatibility), a stack address greater than `seg_limit_i` gives exception code 3 (stack fault). In mode 4 (64-bit), an address whose bits 63:47 are not all equal gives code 3.
- R5: Exception code 4 (alignment) is raised when all of the following hold: `ac_en_i` is set, the stack address is not a multiple of the pop size, and either `cpl_i` is 3 in mode 2, 3 or 4, or the mode is 1 at any privilege level. It is never raised in mode 0.
- R6: With no early exception, one read is requested. `mem_addr_o` is the frame pointer cut to the stack-address width and zero-extended. `mem_size_o` is the effective pop-size code. Both hold steady until `mem_ack_i`.
- R7: If `mem_pf_i` is set with `mem_ack_i`, the result is exception code 5 (page fault).
- R8: Whenever the exception code is non-zero at `done_o`, `sp_o` and `bp_o` equal the `sp_i` and `bp_i` values captured at start.
- R9: On success, `sp_o` is the stack address plus n, where n is 2, 4 or 8 for pop size 16, 32 or 64. For stack size 16, only bits 15:0 change (the sum wraps at 16 bits). For stack size 32, the 32-bit sum is zero-extended. For stack size 64, it is the 64-bit sum.
- R10: On success, `bp_o` is set by the pop size. For pop 16, bits 15:0 come from `mem_data_i` and the upper bits keep the old frame pointer. For pop 32, the low 32 bits of the data are zero-extended. For pop 64, it is the full data word.
- R11: Size codes are 0 = 16, 1 = 32, 2 or 3 = 64. In mode 4, the stack size is always 64, and operand-size code 1 is treated as 64 (8 bytes).
- R12: `done_o` is a one-cycle pulse. It comes two cycles after the accepting edge when an exception is found before the read, and one cycle after the acknowledging edge otherwise. Exception priority is code 1, then codes 2/3, then 4, then 5. Code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Decoded instruction valid |
| opcode_i | input | 8 | Opcode byte |
| lock_i | input | 1 | LOCK prefix present |
| mode_i | input | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| stk_size_i | input | 2 | Stack-address size code |
| op_size_i | input | 2 | Operand size code |
| cpl_i | input | 2 | Current privilege level |
| ac_en_i | input | 1 | Alignment checking enabled |
| seg_limit_i | input | 32 | Stack segment limit |
| sp_i | input | 64 | Current stack pointer |
| bp_i | input | 64 | Current frame pointer |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 64 | Read address |
| mem_size_o | output | 2 | Read size code |
| mem_ack_i | input | 1 | Read completes this cycle |
| mem_pf_i | input | 1 | Read page-faulted (valid with ack) |
| mem_data_i | input | 64 | Read data (valid with ack) |
| done_o | output | 1 | Result valid strobe |
| sp_o | output | 64 | Resulting stack pointer |
| bp_o | output | 64 | Resulting frame pointer |
| exc_o | output | 3 | Exception code, 0 when none |

## Verification
A mistake in the captured request or the size normalisation shows up first at the memory port: at the cycle of the request, `mem_addr_o` or `mem_size_o` differs from the value the bench predicts. A fault check that fires wrongly, or fails to fire, is seen at the `done_o` strobe as a wrong exception code. It also shows as a read request that should not have happened, or as a `done_o` that comes one cycle early or late. A merge error in the result surfaces in `sp_o` or `bp_o` on the very `done_o` cycle, including the upper bits that must be kept.

// File: rtl/frs_pkg.sv
package frs_pkg;

  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_V86    = 3'd1,
    MODE_PROT   = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } cpu_mode_e;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_UD   = 3'd1,
    EXC_GP   = 3'd2,
    EXC_SS   = 3'd3,
    EXC_AC   = 3'd4,
    EXC_PF   = 3'd5
  } exc_code_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_READ  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  localparam logic [1:0] SZ16 = 2'd0;
  localparam logic [1:0] SZ32 = 2'd1;
  localparam logic [1:0] SZ64 = 2'd2;

endpackage

// File: rtl/frs_addr_gen.sv
module frs_addr_gen
  import frs_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2:0]      mode_i,
  input  logic [1:0]      stk_size_i,
  input  logic [1:0]      op_size_i,
  input  logic [XLEN-1:0] bp_i,
  output logic [1:0]      stk_eff_o,
  output logic [1:0]      op_eff_o,
  output logic [XLEN-1:0] addr_o,
  output logic [3:0]      pop_bytes_o
);

  logic long_mode;
  assign long_mode = (mode_i == MODE_LONG);

  always_comb begin
    if (long_mode)                 stk_eff_o = SZ64;
    else if (stk_size_i == SZ16)   stk_eff_o = SZ16;
    else if (stk_size_i == SZ32)   stk_eff_o = SZ32;
    else                           stk_eff_o = SZ64;

    if (op_size_i == SZ16)                 op_eff_o = SZ16;
    else if (op_size_i == SZ32 && !long_mode) op_eff_o = SZ32;
    else                                   op_eff_o = SZ64;
  end

  always_comb begin
    case (stk_eff_o)
      SZ16:    addr_o = {{(XLEN-16){1'b0}}, bp_i[15:0]};
      SZ32:    addr_o = {{(XLEN-32){1'b0}}, bp_i[31:0]};
      default: addr_o = bp_i;
    endcase
    case (op_eff_o)
      SZ16:    pop_bytes_o = 4'd2;
      SZ32:    pop_bytes_o = 4'd4;
      default: pop_bytes_o = 4'd8;
    endcase
  end

endmodule

// File: rtl/frs_fault_check.sv
module frs_fault_check
  import frs_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48,
  parameter int LIMIT_W = 32
) (
  input  logic [2:0]         mode_i,
  input  logic               lock_i,
  input  logic [1:0]         cpl_i,
  input  logic               ac_en_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic [XLEN-1:0]    addr_i,
  input  logic [3:0]         pop_bytes_i,
  output logic [2:0]         exc_o
);

  localparam int REAL_BITS = 16;
  localparam int UPPER_W   = XLEN - VA_BITS + 1;

  logic               real_like;
  logic               real_oob;
  logic               limit_oob;
  logic               noncanon;
  logic               misalign;
  logic               ac_priv;
  logic [UPPER_W-1:0] upper;

  assign real_like = (mode_i == MODE_REAL) || (mode_i == MODE_V86);
  assign real_oob  = |addr_i[XLEN-1:REAL_BITS];
  assign limit_oob = addr_i > {{(XLEN-LIMIT_W){1'b0}}, limit_i};
  assign upper     = addr_i[XLEN-1:VA_BITS-1];
  assign noncanon  = !((&upper) || !(|upper));
  assign misalign  = |(addr_i[3:0] & (pop_bytes_i - 4'd1));
  assign ac_priv   = (mode_i == MODE_V86) ||
                     ((mode_i != MODE_REAL) && (cpl_i == 2'd3));

  always_comb begin
    exc_o = EXC_NONE;
    if (lock_i) begin
      exc_o = EXC_UD;
    end else if (real_like && real_oob) begin
      exc_o = EXC_GP;
    end else if ((mode_i == MODE_LONG) && noncanon) begin
      exc_o = EXC_SS;
    end else if (!real_like && (mode_i != MODE_LONG) && limit_oob) begin
      exc_o = EXC_SS;
    end else if (ac_en_i && misalign && ac_priv) begin
      exc_o = EXC_AC;
    end
  end

endmodule

// File: rtl/frs_result_merge.sv
module frs_result_merge
  import frs_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      stk_eff_i,
  input  logic [1:0]      op_eff_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [3:0]      pop_bytes_i,
  input  logic [XLEN-1:0] old_sp_i,
  input  logic [XLEN-1:0] old_bp_i,
  input  logic [XLEN-1:0] data_i,
  output logic [XLEN-1:0] sp_new_o,
  output logic [XLEN-1:0] bp_new_o
);

  logic [XLEN-1:0] sum;
  assign sum = addr_i + {{(XLEN-4){1'b0}}, pop_bytes_i};

  always_comb begin
    case (stk_eff_i)
      SZ16:    sp_new_o = {old_sp_i[XLEN-1:16], sum[15:0]};
      SZ32:    sp_new_o = {{(XLEN-32){1'b0}}, sum[31:0]};
      default: sp_new_o = sum;
    endcase
    case (op_eff_i)
      SZ16:    bp_new_o = {old_bp_i[XLEN-1:16], data_i[15:0]};
      SZ32:    bp_new_o = {{(XLEN-32){1'b0}}, data_i[31:0]};
      default: bp_new_o = data_i;
    endcase
  end

endmodule

// File: rtl/frame_release_seq.sv
module frame_release_seq
  import frs_pkg::*;
#(
  parameter int         XLEN    = 64,
  parameter int         VA_BITS = 48,
  parameter int         LIMIT_W = 32,
  parameter logic [7:0] OPCODE  = 8'hC9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [7:0]         opcode_i,
  input  logic               lock_i,
  input  logic [2:0]         mode_i,
  input  logic [1:0]         stk_size_i,
  input  logic [1:0]         op_size_i,
  input  logic [1:0]         cpl_i,
  input  logic               ac_en_i,
  input  logic [LIMIT_W-1:0] seg_limit_i,
  input  logic [XLEN-1:0]    sp_i,
  input  logic [XLEN-1:0]    bp_i,
  output logic               mem_req_o,
  output logic [XLEN-1:0]    mem_addr_o,
  output logic [1:0]         mem_size_o,
  input  logic               mem_ack_i,
  input  logic               mem_pf_i,
  input  logic [XLEN-1:0]    mem_data_i,
  output logic               done_o,
  output logic [XLEN-1:0]    sp_o,
  output logic [XLEN-1:0]    bp_o,
  output logic [2:0]         exc_o
);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  seq_state_e state_q, state_d;

  // captured request
  logic [2:0]         mode_q;
  logic [1:0]         stk_q, op_q, cpl_q;
  logic               ac_q, lock_q;
  logic [LIMIT_W-1:0] lim_q;
  logic [XLEN-1:0]    sp_q, bp_q;

  // result registers
  logic [XLEN-1:0]    sp_res_q, sp_res_d, bp_res_q, bp_res_d;
  logic [2:0]         exc_q, exc_d;

  logic accept, res_en;

  // derived views of the captured request
  logic [1:0]      stk_eff, op_eff;
  logic [XLEN-1:0] addr;
  logic [3:0]      pop_bytes;
  logic [2:0]      fault;
  logic [XLEN-1:0] sp_new, bp_new;

  frs_addr_gen #(.XLEN(XLEN)) u_addr (
    .mode_i      (mode_q),
    .stk_size_i  (stk_q),
    .op_size_i   (op_q),
    .bp_i        (bp_q),
    .stk_eff_o   (stk_eff),
    .op_eff_o    (op_eff),
    .addr_o      (addr),
    .pop_bytes_o (pop_bytes)
  );

  frs_fault_check #(.XLEN(XLEN), .VA_BITS(VA_BITS), .LIMIT_W(LIMIT_W)) u_fault (
    .mode_i      (mode_q),
    .lock_i      (lock_q),
    .cpl_i       (cpl_q),
    .ac_en_i     (ac_q),
    .limit_i     (lim_q),
    .addr_i      (addr),
    .pop_bytes_i (pop_bytes),
    .exc_o       (fault)
  );

  frs_result_merge #(.XLEN(XLEN)) u_merge (
    .stk_eff_i   (stk_eff),
    .op_eff_i    (op_eff),
    .addr_i      (addr),
    .pop_bytes_i (pop_bytes),
    .old_sp_i    (sp_q),
    .old_bp_i    (bp_q),
    .data_i      (mem_data_i),
    .sp_new_o    (sp_new),
    .bp_new_o    (bp_new)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    res_en   = 1'b0;
    exc_d    = exc_q;
    sp_res_d = sp_res_q;
    bp_res_d = bp_res_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i && (opcode_i == OPCODE)) begin
          accept  = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (fault != EXC_NONE) begin
          res_en   = 1'b1;
          exc_d    = fault;
          sp_res_d = sp_q;
          bp_res_d = bp_q;
          state_d  = ST_DONE;
        end else begin
          state_d  = ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ack_i) begin
          res_en  = 1'b1;
          state_d = ST_DONE;
          if (mem_pf_i) begin
            exc_d    = EXC_PF;
            sp_res_d = sp_q;
            bp_res_d = bp_q;
          end else begin
            exc_d    = EXC_NONE;
            sp_res_d = sp_new;
            bp_res_d = bp_new;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // request capture, enabled on accept
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= '0; stk_q <= '0; op_q <= '0; cpl_q <= '0;
      ac_q   <= 1'b0; lock_q <= 1'b0; lim_q <= '0;
      sp_q   <= '0; bp_q <= '0;
    end else if (accept) begin
      mode_q <= mode_i; stk_q <= stk_size_i; op_q <= op_size_i; cpl_q <= cpl_i;
      ac_q   <= ac_en_i; lock_q <= lock_i; lim_q <= seg_limit_i;
      sp_q   <= sp_i; bp_q <= bp_i;
    end
  end

  // result registers, enabled on completion
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sp_res_q <= '0;
      bp_res_q <= '0;
      exc_q    <= EXC_NONE;
    end else if (res_en) begin
      sp_res_q <= sp_res_d;
      bp_res_q <= bp_res_d;
      exc_q    <= exc_d;
    end
  end

  assign mem_req_o  = (state_q == ST_READ);
  assign mem_addr_o = addr;
  assign mem_size_o = op_eff;
  assign done_o     = (state_q == ST_DONE);
  assign sp_o       = sp_res_q;
  assign bp_o       = bp_res_q;
  assign exc_o      = exc_q;

  // assertions
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_size_o)));

  assert_fault_keeps_regs_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && exc_o != EXC_NONE) |-> (sp_o == sp_q && bp_o == bp_q));

  assert_lock_no_read_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_CHECK && lock_q) |=> (!mem_req_o && done_o && exc_o == EXC_UD));

  assert_pf_after_read_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && exc_o == EXC_PF) |-> $past(mem_req_o && mem_ack_i && mem_pf_i));

  assert_ac_enabled_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && exc_o == EXC_AC) |-> (ac_q && mode_q != MODE_REAL));

endmodule

// File: tb/frame_release_seq_bench.sv
module frame_release_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  opcode_i;
  logic        lock_i;
  logic [2:0]  mode_i;
  logic [1:0]  stk_size_i, op_size_i, cpl_i;
  logic        ac_en_i;
  logic [31:0] seg_limit_i;
  logic [63:0] sp_i, bp_i;
  logic        mem_req_o;
  logic [63:0] mem_addr_o;
  logic [1:0]  mem_size_o;
  logic        mem_ack_i, mem_pf_i;
  logic [63:0] mem_data_i;
  logic        done_o;
  logic [63:0] sp_o, bp_o;
  logic [2:0]  exc_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  frame_release_seq u_frame_release_seq (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected-value model from the requirements
  function automatic logic [1:0] m_stk(input logic [2:0] m, input logic [1:0] s);
    if (m == 3'd4) return 2'd2;
    if (s == 2'd3) return 2'd2;
    return s;
  endfunction

  function automatic logic [1:0] m_op(input logic [2:0] m, input logic [1:0] s);
    if (s == 2'd0) return 2'd0;
    if (s == 2'd1 && m != 3'd4) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [63:0] m_bytes(input logic [1:0] o);
    return (o == 2'd0) ? 64'd2 : (o == 2'd1) ? 64'd4 : 64'd8;
  endfunction

  function automatic logic [63:0] m_addr(input logic [1:0] s, input logic [63:0] bp);
    if (s == 2'd0) return {48'd0, bp[15:0]};
    if (s == 2'd1) return {32'd0, bp[31:0]};
    return bp;
  endfunction

  function automatic logic [2:0] m_early(input logic [2:0] m, input logic lk,
      input logic [1:0] cp, input logic ac, input logic [31:0] lim,
      input logic [63:0] a, input logic [63:0] n);
    if (lk) return 3'd1;
    if ((m == 3'd0 || m == 3'd1) && a > 64'hFFFF) return 3'd2;
    if (m == 3'd4 && !(a[63:47] == 17'h1FFFF || a[63:47] == 17'h0)) return 3'd3;
    if (m != 3'd0 && m != 3'd1 && m != 3'd4 && a > {32'd0, lim}) return 3'd3;
    if (ac && (a % n) != 0 && (m == 3'd1 || (m != 3'd0 && cp == 2'd3))) return 3'd4;
    return 3'd0;
  endfunction

  function automatic string exc_req(input logic [2:0] e);
    case (e)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic do_op(input logic [2:0] m, input logic [1:0] ss, input logic [1:0] os,
      input logic [1:0] cp, input logic ac, input logic lk, input logic [31:0] lim,
      input logic [63:0] sp, input logic [63:0] bp, input logic [63:0] data,
      input logic pf, input int dly);
    logic [1:0]  se, oe;
    logic [63:0] a, n, esp, ebp;
    logic [2:0]  early, eexc;
    bit          seen_req, got, acked;
    int          waitc, lat;
    se = m_stk(m, ss);
    oe = m_op(m, os);
    a  = m_addr(se, bp);
    n  = m_bytes(oe);
    early = m_early(m, lk, cp, ac, lim, a, n);
    eexc  = (early != 3'd0) ? early : (pf ? 3'd5 : 3'd0);
    if (eexc != 3'd0) begin
      esp = sp; ebp = bp;
    end else begin
      case (se)
        2'd0:    esp = {sp[63:16], a[15:0] + n[15:0]};
        2'd1:    esp = {32'd0, a[31:0] + n[31:0]};
        default: esp = a + n;
      endcase
      case (oe)
        2'd0:    ebp = {bp[63:16], data[15:0]};
        2'd1:    ebp = {32'd0, data[31:0]};
        default: ebp = data;
      endcase
    end
    @(negedge clk);
    start_i = 1'b1; opcode_i = 8'hC9; lock_i = lk; mode_i = m;
    stk_size_i = ss; op_size_i = os; cpl_i = cp; ac_en_i = ac;
    seg_limit_i = lim; sp_i = sp; bp_i = bp;
    @(negedge clk);
    start_i = 1'b0;
    seen_req = 0; got = 0; acked = 0; waitc = 0; lat = -1;
    for (int i = 0; i < 40 && !got; i++) begin
      if (done_o) begin
        got = 1; lat = i;
      end else begin
        if (mem_req_o && !acked) begin
          if (!seen_req) begin
            chk(mem_addr_o == a, "R6", "read address", mem_addr_o, a);
            chk(mem_size_o == oe, (m == 3'd4) ? "R11" : "R6", "read size",
                {62'd0, mem_size_o}, {62'd0, oe});
          end
          seen_req = 1;
          if (waitc >= dly) begin
            mem_ack_i = 1'b1; mem_pf_i = pf; mem_data_i = data; acked = 1;
          end else begin
            waitc++;
          end
        end
        @(negedge clk);
        mem_ack_i = 1'b0; mem_pf_i = 1'b0;
      end
    end
    chk(got, "R12", "done strobe seen", {63'd0, got}, 64'd1);
    chk(seen_req == (early == 3'd0), exc_req(early), "read issued",
        {63'd0, seen_req}, {63'd0, early == 3'd0});
    chk(lat == ((early != 3'd0) ? 1 : 2 + dly), "R12", "done latency",
        64'(lat), 64'((early != 3'd0) ? 1 : 2 + dly));
    chk(exc_o == eexc, exc_req(eexc), "exception code", {61'd0, exc_o}, {61'd0, eexc});
    chk(sp_o == esp, (eexc != 3'd0) ? "R8" : "R9", "stack pointer", sp_o, esp);
    chk(bp_o == ebp, (eexc != 3'd0) ? "R8" : "R10", "frame pointer", bp_o, ebp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R12 watchdog: actual %h expected %h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rbp, keep_sp, keep_bp;
    logic [2:0]  rm;
    bit          seen;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start_i = 1'b0; opcode_i = 8'h00; lock_i = 1'b0; mode_i = 3'd0;
    stk_size_i = 2'd0; op_size_i = 2'd0; cpl_i = 2'd0; ac_en_i = 1'b0;
    seg_limit_i = 32'd0; sp_i = 64'd0; bp_i = 64'd0;
    mem_ack_i = 1'b0; mem_pf_i = 1'b0; mem_data_i = 64'd0;
    repeat (5) @(negedge clk);
    chk(!done_o && !mem_req_o, "R12", "reset outputs idle",
        {62'd0, done_o, mem_req_o}, 64'd0);
    chk(exc_o == 3'd0 && sp_o == 64'd0 && bp_o == 64'd0, "R8", "reset results",
        sp_o | bp_o, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corner cases
    do_op(3'd4, 2'd2, 2'd2, 2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 64'h100, 64'h2000, 64'h1, 1'b0, 0); // R2
    do_op(3'd0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, 64'h50, 64'h0001_0000, 64'h1, 1'b0, 0);   // R3
    do_op(3'd1, 2'd1, 2'd1, 2'd0, 1'b0, 1'b0, 32'h0, 64'h50, 64'h0002_0010, 64'h1, 1'b0, 0);   // R3 v86
    do_op(3'd2, 2'd1, 2'd1, 2'd3, 1'b0, 1'b0, 32'h0000_0FFF, 64'h0, 64'h1000, 64'h1, 1'b0, 0); // R4 limit
    do_op(3'd4, 2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 32'h0, 64'h0, 64'h0000_8000_0000_0000, 64'h1, 1'b0, 0); // R4 canonical
    do_op(3'd1, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 32'h0, 64'h0, 64'h0000_0102, 64'h1, 1'b0, 0);   // R5 v86 any cpl
    do_op(3'd2, 2'd1, 2'd1, 2'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, 64'h0, 64'h1002, 64'hAABB_CCDD, 1'b0, 1); // R5 cpl0 no fault
    do_op(3'd0, 2'd0, 2'd0, 2'd3, 1'b1, 1'b0, 32'h0, 64'h0, 64'h0000_0001, 64'h1234, 1'b0, 0); // R5 never real
    do_op(3'd2, 2'd1, 2'd2, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 64'h0, 64'h800, 64'h1, 1'b1, 2); // R7
    do_op(3'd4, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 32'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0,
          64'hDEAD_BEEF_0123_4567, 1'b0, 0); // R11 forced 64/64
    do_op(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, 64'hABCD_EF01_2345_0000,
          64'h9999_8888_7777_FFFE, 64'h0000_0000_0000_5A5A, 1'b0, 0); // R9/R10 16-bit wrap
    do_op(3'd3, 2'd1, 2'd1, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 64'h1111_2222_3333_4444,
          64'h5555_6666_FFFF_FFFC, 64'hFFFF_FFFF_8765_4321, 1'b0, 3); // R9/R10 32-bit

    // R1: other opcode is ignored
    keep_sp = sp_o; keep_bp = bp_o;
    @(negedge clk);
    start_i = 1'b1; opcode_i = 8'h90; bp_i = 64'h4444; sp_i = 64'h3333; lock_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (mem_req_o || done_o) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R1", "foreign opcode activity", {63'd0, seen}, 64'd0);
    chk(sp_o == keep_sp && bp_o == keep_bp, "R1", "foreign opcode results kept",
        sp_o ^ keep_sp, 64'd0);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      rm = 3'($urandom % 5);
      case ($urandom % 4)
        0: rbp = {$urandom, $urandom};
        1: rbp = {48'd0, 16'($urandom)};
        2: rbp = {32'd0, $urandom};
        default: rbp = (($urandom % 2) != 0) ? {17'h1FFFF, 47'({$urandom, $urandom})}
                                             : {17'h0, 47'({$urandom, $urandom})};
      endcase
      do_op(rm, 2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
            (($urandom % 16) == 0), (($urandom % 2) != 0) ? 32'hFFFF_FFFF : $urandom,
            {$urandom, $urandom}, rbp, {$urandom, $urandom},
            (($urandom % 10) == 0), int'($urandom % 4));
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule